// File: doc/BRIEF.md
# Sixteen-Bit PWM Compare Channel

This block is one compare channel of a counter array, set up for 16-bit pulse-width modulation. It contains a free-running 16-bit timebase that advances by one on each cycle where the increment enable is high. It also holds a 16-bit compare value, which the CPU loads through two byte-wide write strobes. The PWM output goes high on the step that brings the timebase equal to the compare value. It goes low on the step where the timebase wraps from all-ones to zero. The compare value therefore sets how many timebase steps the output stays low in each 65536-step period.

Writing the low byte of the compare value switches the compare off. Writing the high byte switches it back on. If software writes the low byte first and the high byte second, the compare stays off while the value is half-written. A half-written value then cannot produce a stray rising edge. Two sticky flags mark the edges of the waveform. One is set on each rising-edge match, if match flagging is enabled. The other is set on each wrap. Each flag has its own clear strobe, so software can time its updates to the waveform.

Top module: `pwm16_channel`

## Requirements
- R1: After reset the timebase, the compare value, the compare enable, both flags and the PWM output are all 0.
- R2: The timebase rises by one on each clock where `tick` is 1. From 0xFFFF it steps to 0x0000. While `tick` is 0 it holds its value.
- R3: The PWM output becomes 1 on the clock edge where a tick moves the timebase onto the compare value, provided the channel is active.
- R4: The PWM output becomes 0 on the clock edge where the timebase wraps to 0, unless a match at 0 happens on that same edge. In that case the set wins, so a compare value of 0 holds the output at 1 continuously. The output changes on no other edge.
- R5: A `wr_lo` strobe loads `wr_data` into compare bits 7:0 and clears the compare enable. A `wr_hi` strobe loads bits 15:8 and sets the enable. If both strobes arrive on the same edge, the enable ends up set. Neither write changes the PWM output by itself.
- R6: The channel is active only while the compare enable, `pwm_en` and `sel16` are all 1. While it is inactive, no match sets the output or the match flag.
- R7: On a match while active with `match_ie` = 1, `match_flag` becomes 1. With `match_ie` = 0, the output still rises but the flag is left unchanged.
- R8: `ovf_flag` becomes 1 on every timebase wrap, whether or not the channel is active.
- R9: Both flags are sticky. Each is cleared only by its own strobe (`clr_match`, `clr_ovf`). If a set event and a clear strobe arrive on the same edge, the set wins.
- R10: Once a full period has passed with a fixed compare value C, the output is 1 for exactly 65536 − C timebase steps of each period. C = 0xFFFF gives one step, and C = 0 gives all steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase increment enable |
| wr_lo | input | 1 | Write strobe for compare bits 7:0; clears compare enable |
| wr_hi | input | 1 | Write strobe for compare bits 15:8; sets compare enable |
| wr_data | input | 8 | Byte written by either strobe |
| pwm_en | input | 1 | PWM function select |
| sel16 | input | 1 | 16-bit width select |
| match_ie | input | 1 | Enables setting of the match flag |
| clr_match | input | 1 | Clears the match flag |
| clr_ovf | input | 1 | Clears the overflow flag |
| count | output | 16 | Current timebase value |
| pwm_out | output | 1 | PWM waveform |
| match_flag | output | 1 | Sticky rising-edge match flag |
| ovf_flag | output | 1 | Sticky wrap flag |

## Verification
The bound checker watches the cycle-level rules on every cycle:
- the timebase step and hold;
- the output set on a match and the clear on a wrap that has no match;
- the output holding steady between events;
- the enable changes caused by each byte write;
- flags that latch and stay set until cleared;
- the absence of any rising output edge while the channel is inactive.

Only the bench's scenarios can show the whole-period properties. These are the exact count of high steps for compare values 0xFFFF and 0, the continuous high level when the set and clear coincide at zero, and the way a low-byte-only write leaves a high output untouched while it blocks later matches.

// File: rtl/pwm16_pkg.sv
package pwm16_pkg;

  typedef struct packed {
    logic pwm_en;
    logic sel16;
    logic match_ie;
  } mode_t;

  // Channel drives matches only when all three gates are open.
  function automatic logic mode_live(mode_t m, logic cmp_en);
    return cmp_en & m.pwm_en & m.sel16;
  endfunction

  // Next output level: a set event dominates a clear event.
  function automatic logic out_next(logic cur, logic set_ev, logic clr_ev);
    if (set_ev)      return 1'b1;
    else if (clr_ev) return 1'b0;
    else             return cur;
  endfunction

  // Sticky flag: hardware set dominates software clear.
  function automatic logic flag_next(logic cur, logic set_ev, logic clr_strobe);
    if (set_ev)          return 1'b1;
    else if (clr_strobe) return 1'b0;
    else                 return cur;
  endfunction

endpackage

// File: rtl/pwm16_timebase.sv
module pwm16_timebase #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] next_cnt,
  output logic             wrap_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  assign next_cnt = cnt_q + 1'b1;
  assign wrap_evt = tick && (cnt_q == CNT_MAX);
  assign count    = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= next_cnt;
  end
endmodule

// File: rtl/pwm16_cmp_reg.sv
module pwm16_cmp_reg #(
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [CNT_W/2-1:0] wr_data,
  output logic [CNT_W-1:0]   cmp_val,
  output logic               cmp_en
);
  localparam int unsigned HALF_W = CNT_W / 2;
  localparam int unsigned NHALF  = 2;

  logic [HALF_W-1:0] half_q [NHALF];
  logic              en_q;

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    logic wr_this;
    assign wr_this = (h == 0) ? wr_lo : wr_hi;
    always_ff @(posedge clk) begin
      if (!rst_n)       half_q[h] <= '0;
      else if (wr_this) half_q[h] <= wr_data;
    end
  end

  // Upper write re-arms the compare; lower write disarms it.
  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (wr_hi) en_q <= 1'b1;
    else if (wr_lo) en_q <= 1'b0;
  end

  assign cmp_val = {half_q[1], half_q[0]};
  assign cmp_en  = en_q;
endmodule

// File: rtl/pwm16_out_flags.sv
module pwm16_out_flags
  import pwm16_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic match_evt,
  input  logic wrap_evt,
  input  logic match_ie,
  input  logic clr_match,
  input  logic clr_ovf,
  output logic pwm_out,
  output logic match_flag,
  output logic ovf_flag
);
  logic out_q, mflag_q, oflag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q   <= 1'b0;
      mflag_q <= 1'b0;
      oflag_q <= 1'b0;
    end else begin
      out_q   <= out_next(out_q, match_evt, wrap_evt);
      mflag_q <= flag_next(mflag_q, match_evt & match_ie, clr_match);
      oflag_q <= flag_next(oflag_q, wrap_evt, clr_ovf);
    end
  end

  assign pwm_out    = out_q;
  assign match_flag = mflag_q;
  assign ovf_flag   = oflag_q;
endmodule

// File: rtl/pwm16_channel.sv
module pwm16_channel
  import pwm16_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [CNT_W/2-1:0] wr_data,
  input  logic               pwm_en,
  input  logic               sel16,
  input  logic               match_ie,
  input  logic               clr_match,
  input  logic               clr_ovf,
  output logic [CNT_W-1:0]   count,
  output logic               pwm_out,
  output logic               match_flag,
  output logic               ovf_flag
);
  logic [CNT_W-1:0] next_cnt;
  logic [CNT_W-1:0] cmp_val;
  logic             cmp_en;
  logic             wrap_evt;
  logic             match_evt;
  logic             mode_active;
  mode_t            mode;

  assign mode        = '{pwm_en: pwm_en, sel16: sel16, match_ie: match_ie};
  assign mode_active = mode_live(mode, cmp_en);
  // A match is the step that lands the timebase on the compare value.
  assign match_evt   = tick && mode_active && (next_cnt == cmp_val);

  pwm16_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .count    (count),
    .next_cnt (next_cnt),
    .wrap_evt (wrap_evt)
  );

  pwm16_cmp_reg #(.CNT_W(CNT_W)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .wr_data (wr_data),
    .cmp_val (cmp_val),
    .cmp_en  (cmp_en)
  );

  pwm16_out_flags u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .match_evt  (match_evt),
    .wrap_evt   (wrap_evt),
    .match_ie   (mode.match_ie),
    .clr_match  (clr_match),
    .clr_ovf    (clr_ovf),
    .pwm_out    (pwm_out),
    .match_flag (match_flag),
    .ovf_flag   (ovf_flag)
  );
endmodule

// File: rtl/pwm16_channel_chk.sv
module pwm16_channel_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wr_lo,
  input logic             wr_hi,
  input logic             match_ie,
  input logic             clr_match,
  input logic             clr_ovf,
  input logic [CNT_W-1:0] count,
  input logic             pwm_out,
  input logic             match_flag,
  input logic             ovf_flag,
  input logic             cmp_en,
  input logic             mode_active,
  input logic             match_evt,
  input logic             wrap_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == CNT_MAX) |=> count == '0);
  a_r3_set_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> pwm_out);
  a_r4_clear_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !match_evt) |=> !pwm_out);
  a_r4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_evt && !wrap_evt) |=> $stable(pwm_out));
  a_r5_lo_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> !cmp_en);
  a_r5_hi_arms: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> cmp_en);
  a_r6_no_rise_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_active |=> !$rose(pwm_out));
  a_r7_flag_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && match_ie) |=> match_flag);
  a_r8_ovf_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> ovf_flag);
  a_r9_match_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && !clr_match) |=> match_flag);
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr_ovf) |=> ovf_flag);
endmodule

bind pwm16_channel pwm16_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .wr_lo       (wr_lo),
  .wr_hi       (wr_hi),
  .match_ie    (match_ie),
  .clr_match   (clr_match),
  .clr_ovf     (clr_ovf),
  .count       (count),
  .pwm_out     (pwm_out),
  .match_flag  (match_flag),
  .ovf_flag    (ovf_flag),
  .cmp_en      (cmp_en),
  .mode_active (mode_active),
  .match_evt   (match_evt),
  .wrap_evt    (wrap_evt)
);

// File: tb/pwm16_channel_tb_top.sv
module pwm16_channel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 180000;
  localparam int NVEC       = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, wr_lo = 1'b0, wr_hi = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        pwm_en = 1'b0, sel16 = 1'b0, match_ie = 1'b0;
  logic        clr_match = 1'b0, clr_ovf = 1'b0;
  logic [15:0] count;
  logic        pwm_out, match_flag, ovf_flag;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm16_channel dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wr_data(wr_data), .pwm_en(pwm_en), .sel16(sel16), .match_ie(match_ie),
    .clr_match(clr_match), .clr_ovf(clr_ovf), .count(count),
    .pwm_out(pwm_out), .match_flag(match_flag), .ovf_flag(ovf_flag)
  );

  // Fields: cmp[37:22] ticks[21:6] pwm_en[5] sel16[4] match_ie[3]
  //         hi_write[2] exp_out[1] exp_match_flag[0]
  localparam logic [37:0] VEC [NVEC] = '{
    {16'd10,    16'd9,     4'b1111, 2'b00},  // R3 one step before match
    {16'd10,    16'd10,    4'b1111, 2'b11},  // R3 R7 on match
    {16'd10,    16'd20,    4'b1111, 2'b11},  // R4 R9 held high, flag sticky
    {16'd10,    16'd10,    4'b1101, 2'b10},  // R7 flag gated off
    {16'd10,    16'd10,    4'b1110, 2'b00},  // R5 R6 low byte only: disarmed
    {16'd10,    16'd10,    4'b0111, 2'b00},  // R6 pwm_en low
    {16'd10,    16'd10,    4'b1011, 2'b00},  // R6 sel16 low
    {16'h0100,  16'h0100,  4'b1111, 2'b11}   // R3 R5 upper byte reaches compare
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; wr_lo = 1'b0; wr_hi = 1'b0;
    clr_match = 1'b0; clr_ovf = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic write_lo(logic [7:0] d);
    @(negedge clk); wr_lo = 1'b1; wr_data = d;
    @(negedge clk); wr_lo = 1'b0;
  endtask

  task automatic write_hi(logic [7:0] d);
    @(negedge clk); wr_hi = 1'b1; wr_data = d;
    @(negedge clk); wr_hi = 1'b0;
  endtask

  task automatic run_ticks(int n);
    if (n > 0) begin
      tick = 1'b1;
      for (int k = 0; k < n; k++) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles >= WATCHDOG && !done) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, WATCHDOG);
        finish_run();
      end
    end
  end

  initial begin
    // R1: reset state
    do_reset();
    @(negedge clk);
    check("R1 count", count, 0);
    check("R1 pwm_out", pwm_out, 0);
    check("R1 match_flag", match_flag, 0);
    check("R1 ovf_flag", ovf_flag, 0);

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [37:0] e;
      e = VEC[v];
      do_reset();
      pwm_en = e[5]; sel16 = e[4]; match_ie = e[3];
      write_lo(e[29:22]);
      if (e[2]) write_hi(e[37:30]);
      run_ticks(int'(e[21:6]));
      check($sformatf("R2 vec%0d count", v), count, e[21:6]);
      check($sformatf("R3 R6 vec%0d pwm_out", v), pwm_out, e[1]);
      check($sformatf("R7 vec%0d match_flag", v), match_flag, e[0]);
    end

    // R9 clear strobe, R5 low-byte write leaves output and disarms
    do_reset();
    pwm_en = 1'b1; sel16 = 1'b1; match_ie = 1'b1;
    write_lo(8'd10); write_hi(8'd0);
    run_ticks(12);
    check("R3 directed high", pwm_out, 1);
    @(negedge clk); clr_match = 1'b1;
    @(negedge clk); clr_match = 1'b0;
    check("R9 match cleared", match_flag, 0);
    check("R9 output untouched by clear", pwm_out, 1);
    write_lo(8'h20);
    check("R5 low write keeps output", pwm_out, 1);
    run_ticks(30);
    check("R6 disarmed: no new match", match_flag, 0);
    check("R4 no wrap yet: stays high", pwm_out, 1);

    // R10 / R4 / R8: compare 0xFFFF over a full period
    do_reset();
    pwm_en = 1'b1; sel16 = 1'b1; match_ie = 1'b1;
    write_lo(8'hFF); write_hi(8'hFF);
    begin
      int hi_cnt = 0;
      tick = 1'b1;
      for (int k = 0; k < 65536; k++) begin
        @(negedge clk);
        if (pwm_out) hi_cnt++;
      end
      tick = 1'b0;
      check("R10 duty for 0xFFFF (high steps)", hi_cnt, 1);
    end
    check("R2 wrapped to zero", count, 0);
    check("R4 low after wrap", pwm_out, 0);
    check("R8 ovf set on wrap", ovf_flag, 1);
    check("R7 flag from 0xFFFF match", match_flag, 1);

    // R4 set wins at zero: compare 0 gives continuous high
    write_lo(8'h00); write_hi(8'h00);
    @(negedge clk); clr_ovf = 1'b1;
    @(negedge clk); clr_ovf = 1'b0;
    check("R9 ovf cleared", ovf_flag, 0);
    begin
      int hi_cnt = 0;
      tick = 1'b1;
      for (int k = 0; k < 65536; k++) begin
        @(negedge clk);
        if (pwm_out) hi_cnt++;
      end
      check("R4 high once wrap meets match at 0", pwm_out, 1);
      check("R4 only the wrap step high in first period", hi_cnt, 1);
      hi_cnt = 0;
      for (int k = 0; k < 256; k++) begin
        @(negedge clk);
        if (pwm_out) hi_cnt++;
      end
      tick = 1'b0;
      check("R10 compare 0 stays high", hi_cnt, 256);
    end
    check("R8 ovf on second wrap", ovf_flag, 1);

    done = 1'b1;
    finish_run();
  end
endmodule